// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block holds the four interrupt flags of one 16-bit timer/counter: input capture, compare channel A, compare channel B and overflow. The timer core sends event strobes, and the block sets each flag on the timer clock enable. A flag is cleared in one of two ways. Software can write a one to its bit through an 8-bit register port. The interrupt controller can also send an acknowledge pulse when it takes the vector for that flag. Each interrupt request output is its flag gated by an enable input.

Two event sources change with the waveform mode. In modes where the capture register sets TOP, the capture flag follows the TOP-reached strobe and not the capture pin event. The overflow flag follows the plain wrap strobe in normal and clear-on-compare modes. In all other modes it follows a condition supplied for that mode. A compare flag is set one timer tick after the tick on which the match was seen. A match that comes with a forced-compare strobe is dropped.

Top module: `tmr_irq_flags`

## Requirements
- R1: Register layout: bit 5 is the capture flag, bit 4 is compare A, bit 3 is compare B and bit 2 is overflow. Bits 7, 6, 1 and 0 always read 0, and writes to them have no effect.
- R2: After reset, every flag and every interrupt request is 0.
- R3: When `cmp_a_match` or `cmp_b_match` is high on a cycle with `tick` high, the flag for that channel is not set on that tick. It is set on the next cycle with `tick` high, and any number of cycles without `tick` may come in between.
- R4: A compare match seen together with `force_a` or `force_b` for the same channel never sets that channel's flag.
- R5: When `wave_mode` is 8, 10, 12 or 14, the capture flag is set by `top_hit` and `cap_evt` is ignored. In every other mode it is set by `cap_evt` and `top_hit` is ignored.
- R6: When `wave_mode` is 0, 4 or 12, the overflow flag is set by `ovf_evt`. In every other mode it is set by `mode_ovf`, and the other input is ignored.
- R7: An acknowledge pulse clears only its own flag.
- R8: A register write clears each flag whose bit is written 1. A flag whose bit is written 0 keeps its value.
- R9: When a set event arrives on the same cycle as a write-one or an acknowledge for that flag, the flag ends up 1.
- R10: Each interrupt request is high exactly when its flag is 1 and its enable input is 1.
- R11: Events set flags only on cycles with `tick` high. Writes and acknowledges take effect on any clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable |
| wave_mode | input | 4 | Waveform generation mode |
| cap_evt | input | 1 | Capture pin event |
| top_hit | input | 1 | Counter reached TOP |
| cmp_a_match | input | 1 | Counter equals compare A |
| cmp_b_match | input | 1 | Counter equals compare B |
| force_a | input | 1 | Forced compare strobe, channel A |
| force_b | input | 1 | Forced compare strobe, channel B |
| ovf_evt | input | 1 | Counter wrap in normal and clear-on-compare modes |
| mode_ovf | input | 1 | Overflow condition for the other modes |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| ack_cap | input | 1 | Capture vector acknowledge |
| ack_a | input | 1 | Compare A vector acknowledge |
| ack_b | input | 1 | Compare B vector acknowledge |
| ack_ovf | input | 1 | Overflow vector acknowledge |
| en_cap | input | 1 | Capture interrupt enable |
| en_a | input | 1 | Compare A interrupt enable |
| en_b | input | 1 | Compare B interrupt enable |
| en_ovf | input | 1 | Overflow interrupt enable |
| irq_cap | output | 1 | Capture interrupt request |
| irq_a | output | 1 | Compare A interrupt request |
| irq_b | output | 1 | Compare B interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach is the delayed compare flag. The match is captured on one tick and only shows on the next tick, so the stimulus places several cycles without a tick between the two. It checks that the flag stays 0 until that second tick. Collisions need a set event, a write-one or an acknowledge, and a tick all on one cycle. The bench drives them together on a single negative edge so that exactly one clock edge sees them.

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags #(
  parameter int MODE_W = 4,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [MODE_W-1:0] wave_mode,
  input  logic              cap_evt,
  input  logic              top_hit,
  input  logic              cmp_a_match,
  input  logic              cmp_b_match,
  input  logic              force_a,
  input  logic              force_b,
  input  logic              ovf_evt,
  input  logic              mode_ovf,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  input  logic              ack_cap,
  input  logic              ack_a,
  input  logic              ack_b,
  input  logic              ack_ovf,
  input  logic              en_cap,
  input  logic              en_a,
  input  logic              en_b,
  input  logic              en_ovf,
  output logic              irq_cap,
  output logic              irq_a,
  output logic              irq_b,
  output logic              irq_ovf
);
  localparam int B_CAP = 5;
  localparam int B_A   = 4;
  localparam int B_B   = 3;
  localparam int B_OVF = 2;

  logic f_cap, f_a, f_b, f_ovf;
  logic pend_a, pend_b;
  logic top_is_cap, ovf_plain;
  logic set_cap, set_a, set_b, set_ovf;
  logic clr_cap, clr_a, clr_b, clr_ovf;

  assign top_is_cap = (wave_mode == MODE_W'(8))  || (wave_mode == MODE_W'(10)) ||
                      (wave_mode == MODE_W'(12)) || (wave_mode == MODE_W'(14));
  assign ovf_plain  = (wave_mode == MODE_W'(0))  || (wave_mode == MODE_W'(4)) ||
                      (wave_mode == MODE_W'(12));

  assign set_cap = tick & (top_is_cap ? top_hit : cap_evt);
  assign set_a   = tick & pend_a;
  assign set_b   = tick & pend_b;
  assign set_ovf = tick & (ovf_plain ? ovf_evt : mode_ovf);

  assign clr_cap = ack_cap | (wr_en & wr_data[B_CAP]);
  assign clr_a   = ack_a   | (wr_en & wr_data[B_A]);
  assign clr_b   = ack_b   | (wr_en & wr_data[B_B]);
  assign clr_ovf = ack_ovf | (wr_en & wr_data[B_OVF]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_a <= 1'b0;
      pend_b <= 1'b0;
    end else if (tick) begin
      pend_a <= cmp_a_match & ~force_a;
      pend_b <= cmp_b_match & ~force_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_cap <= 1'b0;
      f_a   <= 1'b0;
      f_b   <= 1'b0;
      f_ovf <= 1'b0;
    end else begin
      f_cap <= set_cap | (f_cap & ~clr_cap);
      f_a   <= set_a   | (f_a   & ~clr_a);
      f_b   <= set_b   | (f_b   & ~clr_b);
      f_ovf <= set_ovf | (f_ovf & ~clr_ovf);
    end
  end

  always_comb begin
    rd_data        = '0;
    rd_data[B_CAP] = f_cap;
    rd_data[B_A]   = f_a;
    rd_data[B_B]   = f_b;
    rd_data[B_OVF] = f_ovf;
  end

  assign irq_cap = f_cap & en_cap;
  assign irq_a   = f_a   & en_a;
  assign irq_b   = f_b   & en_b;
  assign irq_ovf = f_ovf & en_ovf;

  assert_flag_needs_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(f_a) || $rose(f_b) || $rose(f_cap) || $rose(f_ovf)) |-> $past(tick));

  assert_cmp_delayed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_a) |-> $past(pend_a));

  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_A] && !tick) |=> !f_a);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ovf && !tick) |=> !f_ovf);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend_b) |=> f_b);

  assert_forced_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && force_a) |=> !pend_a);
endmodule

// File: tb/sim_tmr_irq_flags.sv
module sim_tmr_irq_flags;
  logic clk = 0, rst_n = 0, tick = 0;
  logic [3:0] wave_mode = 0;
  logic cap_evt = 0, top_hit = 0, cmp_a_match = 0, cmp_b_match = 0;
  logic force_a = 0, force_b = 0, ovf_evt = 0, mode_ovf = 0, wr_en = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic ack_cap = 0, ack_a = 0, ack_b = 0, ack_ovf = 0;
  logic en_cap = 0, en_a = 0, en_b = 0, en_ovf = 0;
  logic irq_cap, irq_a, irq_b, irq_ovf;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  tmr_irq_flags u0 (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    {tick, cap_evt, top_hit, cmp_a_match, cmp_b_match, force_a, force_b} = '0;
    {ovf_evt, mode_ovf, wr_en, ack_cap, ack_a, ack_b, ack_ovf} = '0;
    wr_data = 0;
  endtask

  task automatic wipe();
    idle(); wr_en = 1; wr_data = 8'hFF; cyc(); idle();
  endtask

  task automatic t_reset();
    chk("R2 flags", rd_data, 8'h00);
    chk("R2 irqs", {4'b0, irq_cap, irq_a, irq_b, irq_ovf}, 8'h00);
  endtask

  task automatic t_cmp_delay();
    wave_mode = 0;
    tick = 1; cmp_a_match = 1; cyc(); idle();
    chk("R3 not on match tick", rd_data, 8'h00);
    cyc(); cyc(); cyc();
    chk("R3 wait through idle cycles", rd_data, 8'h00);
    tick = 1; cyc(); idle();
    chk("R3 set on next tick", rd_data, 8'h10);
    tick = 1; cmp_b_match = 1; cyc(); idle();
    chk("R3 B not on match tick", rd_data, 8'h10);
    tick = 1; cyc(); idle();
    chk("R3 B set next tick", rd_data, 8'h18);
    wipe();
  endtask

  task automatic t_force();
    tick = 1; cmp_a_match = 1; force_a = 1; cmp_b_match = 1; force_b = 1; cyc(); idle();
    tick = 1; cyc(); idle();
    chk("R4 forced match dropped", rd_data, 8'h00);
  endtask

  task automatic t_w1c_layout();
    wave_mode = 0;
    tick = 1; cmp_a_match = 1; cmp_b_match = 1; ovf_evt = 1; cap_evt = 1; cyc(); idle();
    tick = 1; cyc(); idle();
    chk("R1 layout all four", rd_data, 8'h3C);
    wr_en = 1; wr_data = 8'h00; cyc(); idle();
    chk("R8 zero write keeps", rd_data, 8'h3C);
    wr_en = 1; wr_data = 8'h08; cyc(); idle();
    chk("R8 clear B only", rd_data, 8'h34);
    wr_en = 1; wr_data = 8'hC3; cyc(); idle();
    chk("R1 reserved bits ignored", rd_data, 8'h34);
    wipe();
    chk("R8 clear all", rd_data, 8'h00);
  endtask

  task automatic t_cap();
    wave_mode = 0; tick = 1; top_hit = 1; cyc(); idle();
    chk("R5 top ignored mode 0", rd_data, 8'h00);
    tick = 1; cap_evt = 1; cyc(); idle();
    chk("R5 capture mode 0", rd_data, 8'h20);
    wipe();
    wave_mode = 14; tick = 1; cap_evt = 1; cyc(); idle();
    chk("R5 capture ignored mode 14", rd_data, 8'h00);
    tick = 1; top_hit = 1; cyc(); idle();
    chk("R5 top sets mode 14", rd_data, 8'h20);
    wipe();
  endtask

  task automatic t_ovf();
    wave_mode = 4; tick = 1; mode_ovf = 1; cyc(); idle();
    chk("R6 mode_ovf ignored mode 4", rd_data, 8'h00);
    tick = 1; ovf_evt = 1; cyc(); idle();
    chk("R6 ovf_evt mode 4", rd_data, 8'h04);
    wipe();
    wave_mode = 5; tick = 1; ovf_evt = 1; cyc(); idle();
    chk("R6 ovf_evt ignored mode 5", rd_data, 8'h00);
    tick = 1; mode_ovf = 1; cyc(); idle();
    chk("R6 mode_ovf mode 5", rd_data, 8'h04);
    wave_mode = 0;
    wipe();
  endtask

  task automatic t_ack();
    tick = 1; ovf_evt = 1; cap_evt = 1; cyc(); idle();
    ack_ovf = 1; cyc(); idle();
    chk("R7 ack clears own only", rd_data, 8'h20);
    ack_cap = 1; cyc(); idle();
    chk("R7 ack capture", rd_data, 8'h00);
  endtask

  task automatic t_collide();
    tick = 1; ovf_evt = 1; cyc(); idle();
    tick = 1; ovf_evt = 1; wr_en = 1; wr_data = 8'h04; cyc(); idle();
    chk("R9 set beats write", rd_data, 8'h04);
    tick = 1; ovf_evt = 1; ack_ovf = 1; cyc(); idle();
    chk("R9 set beats ack", rd_data, 8'h04);
    wipe();
  endtask

  task automatic t_irq();
    tick = 1; ovf_evt = 1; cyc(); idle();
    en_ovf = 0; #1;
    chk("R10 irq masked", {7'b0, irq_ovf}, 8'h00);
    en_ovf = 1; #1;
    chk("R10 irq enabled", {7'b0, irq_ovf}, 8'h01);
    en_a = 1; #1;
    chk("R10 no flag no irq", {7'b0, irq_a}, 8'h00);
    en_ovf = 0; en_a = 0;
    wipe();
  endtask

  task automatic t_tick();
    cap_evt = 1; ovf_evt = 1; cyc(); idle();
    chk("R11 no set without tick", rd_data, 8'h00);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); t_reset();
    @(negedge clk); rst_n = 1; @(negedge clk);
    t_reset();
    t_cmp_delay();
    t_force();
    t_w1c_layout();
    t_cap();
    t_ovf();
    t_ack();
    t_collide();
    t_irq();
    t_tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule